// File: doc/BRIEF.md
# Predicated Vector Floating-Point Magnitude Comparator

This block is a vector execution unit with a fixed 128-bit vector length. It executes a predicated compare on the magnitudes of floating-point values. It takes a 32-bit instruction word, two source vectors and a governing predicate that holds one bit per vector byte. The instruction word selects the lane format and the relation. The lane format is half, single or double precision, giving 8, 4 or 2 lanes. The relation is "magnitude greater than" or "magnitude greater than or equal".

For every lane, the block drops the sign of both elements and compares the remaining bits as unsigned integers. It writes one result bit into the destination predicate, at the lowest bit of that lane's byte group. Every other bit of the destination predicate is cleared. A lane whose governing bit is clear gives a zero result. An active lane in which either element is a NaN also gives a zero result, and it raises an invalid-operation indication for the instruction.

Words that do not match the encoding, or that use the reserved size value, raise an undefined-instruction output and produce no result. The four register index fields are decoded and passed on so that the surrounding pipeline can route them. All outputs are registered and appear one cycle after the valid input. The block has no condition-flag output.

Top module: `facmp_unit`

## Requirements
- R1: An instruction is recognised only when bits 31:24 equal 8'h65, bit 21 is 0, bits 15:14 equal 2'b11 and bit 4 is 1. Any other valid word sets undefInstr to 1, sets destPred to 0 and sets invalidOp to 0.
- R2: Bit 13 selects the relation. A value of 1 computes |a| > |b| and a value of 0 computes |a| >= |b|.
- R3: The size field in bits 23:22 sets the lane width to 8 << size. The value 2'b00 sets undefInstr to 1, and in that case destPred and invalidOp are 0.
- R4: Lane e takes its elements from bits [e*W +: W] of each source. Its result goes to destPred bit e*W/8. All other destPred bits are 0. Size 01 gives 8 lanes, 10 gives 4 lanes and 11 gives 2 lanes.
- R5: The sign bit of each element is ignored. Magnitudes are compared as unsigned integers over the exponent and fraction bits, so infinities compare in order.
- R6: A lane is active only when govPred bit e*W/8 is 1. An inactive lane gives a 0 result. The other govPred bits in a lane's group have no effect.
- R7: A value is a NaN when its exponent field is all ones and its fraction is nonzero. The exponent field is 5 bits for half, 8 for single and 11 for double precision. An active lane with a NaN operand gives a 0 result and sets invalidOp. A NaN in an inactive lane does not set invalidOp.
- R8: Positive zero and negative zero compare equal. The greater-or-equal relation gives 1 and the greater-than relation gives 0.
- R9: outValid, destPred, undefInstr and invalidOp appear one clock after inValid. When inValid was 0, all of them are 0.
- R10: The index outputs carry the instruction fields with one cycle of latency: srcBIdx from bits 20:16, predIdx from bits 12:10, srcAIdx from bits 9:5 and destIdx from bits 3:0. All four are 0 when inValid was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| srcA | input | 128 | First source vector |
| srcB | input | 128 | Second source vector |
| govPred | input | 16 | Governing predicate, one bit per byte |
| outValid | output | 1 | Result valid |
| destPred | output | 16 | Destination predicate |
| undefInstr | output | 1 | Instruction word is not a legal encoding |
| invalidOp | output | 1 | An active lane saw a NaN operand |
| srcAIdx | output | 5 | First source register index |
| srcBIdx | output | 5 | Second source register index |
| predIdx | output | 3 | Governing predicate index |
| destIdx | output | 4 | Destination predicate index |

## Verification
The decoded size selects one of three lane banks. If that selection is wrong, the error appears in the result of the same instruction, one cycle later, as result bits at the wrong stride or as lanes cut at the wrong boundary. If the relation strobe is wrong, the equal-magnitude lanes flip, so every directed test places equal magnitudes, including both zeros, in at least one lane. A wrong lane-activity or NaN decision shows up as a single wrong destPred bit or a wrong invalidOp flag. Each directed case is therefore paired with a change to the predicate or to one operand, and the bench checks that this changes exactly the expected bit.

// File: rtl/facmp_pkg.sv
package facmp_pkg;
  // Strobes from the instruction decoder to the lane datapath.
  typedef struct packed {
    logic       fire;     // a word is presented this cycle
    logic       legal;    // word matches the encoding with a usable size
    logic       isGt;     // 1: strict greater, 0: greater or equal
    logic [1:0] sizeSel;  // lane width = 8 << sizeSel
  } facmpCtrl_t;
endpackage

// File: rtl/facmp_ctrl.sv
module facmp_ctrl
  import facmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] instr,
  output facmpCtrl_t  ctrl,
  output logic        outValid,
  output logic        undefInstr,
  output logic [4:0]  srcAIdx,
  output logic [4:0]  srcBIdx,
  output logic [2:0]  predIdx,
  output logic [3:0]  destIdx
);
  logic opMatch;
  logic legal;

  assign opMatch = (instr[31:24] == 8'h65) && !instr[21] &&
                   (instr[15:14] == 2'b11) && instr[4];
  assign legal   = opMatch && (instr[23:22] != 2'b00);

  assign ctrl.fire    = inValid;
  assign ctrl.legal   = legal;
  assign ctrl.isGt    = instr[13];
  assign ctrl.sizeSel = instr[23:22];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      undefInstr <= 1'b0;
      srcAIdx    <= '0;
      srcBIdx    <= '0;
      predIdx    <= '0;
      destIdx    <= '0;
    end else begin
      outValid   <= inValid;
      undefInstr <= inValid && !legal;
      srcBIdx    <= inValid ? instr[20:16] : '0;
      predIdx    <= inValid ? instr[12:10] : '0;
      srcAIdx    <= inValid ? instr[9:5]   : '0;
      destIdx    <= inValid ? instr[3:0]   : '0;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R9
  AST_SIZE_ZERO_UNDEF: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instr[23:22] == 2'b00) |=> undefInstr); // R3
  AST_BAD_OPCODE_UNDEF: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instr[31:24] != 8'h65) |=> undefInstr); // R1
endmodule

// File: rtl/facmp_lanes.sv
module facmp_lanes
  import facmp_pkg::*;
#(
  parameter  int VEC_W  = 128,
  localparam int PRED_W = VEC_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  facmpCtrl_t        ctrl,
  input  logic [VEC_W-1:0]  srcA,
  input  logic [VEC_W-1:0]  srcB,
  input  logic [PRED_W-1:0] govPred,
  output logic [PRED_W-1:0] destPred,
  output logic              invalidOp
);
  logic [PRED_W-1:0] resBySize [4];
  logic              nanBySize [4];

  assign resBySize[0] = '0;
  assign nanBySize[0] = 1'b0;

  // One lane bank per legal element width.
  for (genvar s = 1; s < 4; s++) begin : g_size
    localparam int W     = 8 << s;
    localparam int N     = VEC_W / W;
    localparam int EXPW  = (s == 1) ? 5 : (s == 2) ? 8 : 11;
    localparam int FRACW = W - 1 - EXPW;
    localparam int GRP   = W / 8;

    logic [PRED_W-1:0] res;
    logic              anyNan;
    logic [W-2:0]      magA, magB;
    logic              nanA, nanB, rel;

    always_comb begin
      res    = '0;
      anyNan = 1'b0;
      magA   = '0;
      magB   = '0;
      nanA   = 1'b0;
      nanB   = 1'b0;
      rel    = 1'b0;
      for (int e = 0; e < N; e++) begin
        magA = srcA[e*W +: W-1];
        magB = srcB[e*W +: W-1];
        nanA = (&magA[W-2 -: EXPW]) && (|magA[FRACW-1:0]);
        nanB = (&magB[W-2 -: EXPW]) && (|magB[FRACW-1:0]);
        rel  = ctrl.isGt ? (magA > magB) : (magA >= magB);
        if (govPred[e*GRP]) begin
          res[e*GRP] = !nanA && !nanB && rel;
          if (nanA || nanB) anyNan = 1'b1;
        end
      end
    end

    assign resBySize[s] = res;
    assign nanBySize[s] = anyNan;
  end

  logic [PRED_W-1:0] nextPred;
  logic              nextNan;
  logic [1:0]        sizeQ;

  always_comb begin
    nextPred = '0;
    nextNan  = 1'b0;
    if (ctrl.fire && ctrl.legal) begin
      nextPred = resBySize[ctrl.sizeSel];
      nextNan  = nanBySize[ctrl.sizeSel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      destPred  <= '0;
      invalidOp <= 1'b0;
      sizeQ     <= 2'b00;
    end else begin
      destPred  <= nextPred;
      invalidOp <= nextNan;
      sizeQ     <= (ctrl.fire && ctrl.legal) ? ctrl.sizeSel : 2'b00;
    end
  end

  // Lane-low positions for the size that produced the current result.
  logic [PRED_W-1:0] lowMask;
  always_comb begin
    for (int i = 0; i < PRED_W; i++) begin
      lowMask[i] = (sizeQ != 2'b00) && ((i & ((1 << sizeQ) - 1)) == 0);
    end
  end

  AST_LANE_LOW_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (destPred & ~lowMask) == '0); // R4
  AST_INACTIVE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (destPred & ~$past(govPred)) == '0); // R6
endmodule

// File: rtl/facmp_unit.sv
module facmp_unit
  import facmp_pkg::*;
#(
  parameter  int VEC_W  = 128,
  localparam int PRED_W = VEC_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [31:0]       instr,
  input  logic [VEC_W-1:0]  srcA,
  input  logic [VEC_W-1:0]  srcB,
  input  logic [PRED_W-1:0] govPred,
  output logic              outValid,
  output logic [PRED_W-1:0] destPred,
  output logic              undefInstr,
  output logic              invalidOp,
  output logic [4:0]        srcAIdx,
  output logic [4:0]        srcBIdx,
  output logic [2:0]        predIdx,
  output logic [3:0]        destIdx
);
  facmpCtrl_t ctrl;

  facmp_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .instr      (instr),
    .ctrl       (ctrl),
    .outValid   (outValid),
    .undefInstr (undefInstr),
    .srcAIdx    (srcAIdx),
    .srcBIdx    (srcBIdx),
    .predIdx    (predIdx),
    .destIdx    (destIdx)
  );

  facmp_lanes #(.VEC_W(VEC_W)) lanes_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .srcA      (srcA),
    .srcB      (srcB),
    .govPred   (govPred),
    .destPred  (destPred),
    .invalidOp (invalidOp)
  );

  AST_UNDEF_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    undefInstr |-> (destPred == '0 && !invalidOp)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (destPred == '0 && !invalidOp && !undefInstr)); // R9
endmodule

// File: tb/facmp_unit_tb_top.sv
`timescale 1ns/1ps
module facmp_unit_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] srcA = '0, srcB = '0;
  logic [15:0]  govPred = '0;
  logic         outValid, undefInstr, invalidOp;
  logic [15:0]  destPred;
  logic [4:0]   srcAIdx, srcBIdx;
  logic [2:0]   predIdx;
  logic [3:0]   destIdx;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  facmp_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
    .srcA(srcA), .srcB(srcB), .govPred(govPred),
    .outValid(outValid), .destPred(destPred), .undefInstr(undefInstr),
    .invalidOp(invalidOp), .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
    .predIdx(predIdx), .destIdx(destIdx)
  );

  function automatic logic [31:0] mkInstr(input logic [1:0] sz, input logic gt,
      input logic [4:0] zm, input logic [2:0] pg, input logic [4:0] zn,
      input logic [3:0] pd);
    return {8'h65, sz, 1'b0, zm, 2'b11, gt, pg, zn, 1'b1, pd};
  endfunction

  // Reference model built from the requirements.
  task automatic model(input logic [31:0] ins, input logic [127:0] a, b,
      input logic [15:0] p, output logic [15:0] eP, output logic eInv,
      output logic eUnd);
    logic match;
    int   sz, w, n, ew;
    logic [63:0] ma, mb, magMask, expA, expB, frA, frB;
    logic nA, nB, rel;
    match = (ins[31:24] == 8'h65) && !ins[21] && (ins[15:14] == 2'b11) && ins[4];
    sz = int'(ins[23:22]);
    eP = '0; eInv = 1'b0; eUnd = 1'b0;
    if (!match || sz == 0) begin
      eUnd = 1'b1;
      return;
    end
    w  = 8 << sz;
    n  = 128 / w;
    ew = (sz == 1) ? 5 : (sz == 2) ? 8 : 11;
    magMask = (64'h1 << (w - 1)) - 64'h1;
    for (int e = 0; e < n; e++) begin
      ma = 64'(a >> (e * w)) & magMask;
      mb = 64'(b >> (e * w)) & magMask;
      expA = (ma >> (w - 1 - ew)) & ((64'h1 << ew) - 64'h1);
      expB = (mb >> (w - 1 - ew)) & ((64'h1 << ew) - 64'h1);
      frA = ma & ((64'h1 << (w - 1 - ew)) - 64'h1);
      frB = mb & ((64'h1 << (w - 1 - ew)) - 64'h1);
      nA = (expA == ((64'h1 << ew) - 64'h1)) && (frA != 0);
      nB = (expB == ((64'h1 << ew) - 64'h1)) && (frB != 0);
      rel = ins[13] ? (ma > mb) : (ma >= mb);
      if (p[e * (w / 8)]) begin
        eP[e * (w / 8)] = !nA && !nB && rel;
        if (nA || nB) eInv = 1'b1;
      end
    end
  endtask

  task automatic chk(input string req, input string what,
      input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One instruction in, results sampled at the following negedge.
  task automatic apply(input string req, input logic [31:0] ins,
      input logic [127:0] a, b, input logic [15:0] p,
      input logic [15:0] eP, input logic eInv, input logic eUnd);
    @(negedge clk);
    instr = ins; srcA = a; srcB = b; govPred = p; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk(req, "outValid",   32'(outValid),   32'd1);
    chk(req, "destPred",   32'(destPred),   32'(eP));
    chk(req, "invalidOp",  32'(invalidOp),  32'(eInv));
    chk(req, "undefInstr", 32'(undefInstr), 32'(eUnd));
  endtask

  task automatic applyModel(input string req, input logic [31:0] ins,
      input logic [127:0] a, b, input logic [15:0] p);
    logic [15:0] eP;
    logic eInv, eUnd;
    model(ins, a, b, p, eP, eInv, eUnd);
    apply(req, ins, a, b, p, eP, eInv, eUnd);
  endtask

  // Half-precision operand set shared by several scenarios.
  localparam logic [127:0] HA = {16'hBC00, 16'h3C00, 16'h7C00, 16'h0000,
                                 16'h4000, 16'h3C00, 16'hC000, 16'h3C00};
  localparam logic [127:0] HB = {16'h3C00, 16'hC000, 16'hFC00, 16'h8000,
                                 16'hBC00, 16'h4000, 16'h4000, 16'h3C00};

  task automatic testReset();
    chk("R9", "reset outValid", 32'(outValid), 32'd0);
    chk("R9", "reset destPred", 32'(destPred), 32'd0);
    chk("R10", "reset destIdx", 32'(destIdx), 32'd0);
  endtask

  task automatic testHalf();
    // R2 R5 R8 greater-or-equal across signs, infinities and both zeros
    apply("R2", mkInstr(2'b01, 1'b0, 5'd1, 3'd0, 5'd2, 4'd3), HA, HB, 16'hFFFF,
          16'h4545, 1'b0, 1'b0);
    // R2 R8 strict greater: equal magnitudes and zeros give 0
    apply("R8", mkInstr(2'b01, 1'b1, 5'd1, 3'd0, 5'd2, 4'd3), HA, HB, 16'hFFFF,
          16'h0040, 1'b0, 1'b0);
  endtask

  task automatic testPredicate();
    // R6 only non-lowest bits set: every lane inactive
    apply("R6", mkInstr(2'b01, 1'b0, 5'd1, 3'd0, 5'd2, 4'd3), HA, HB, 16'hAAAA,
          16'h0000, 1'b0, 1'b0);
    // R6 lanes 2 and 3 inactive
    apply("R6", mkInstr(2'b01, 1'b0, 5'd1, 3'd0, 5'd2, 4'd3), HA, HB, 16'h5505,
          16'h4505, 1'b0, 1'b0);
  endtask

  task automatic testNan();
    logic [127:0] a;
    a = HA;
    a[15:0] = 16'h7E00;
    apply("R7", mkInstr(2'b01, 1'b0, 5'd1, 3'd0, 5'd2, 4'd3), a, HB, 16'hFFFF,
          16'h4544, 1'b1, 1'b0);
    apply("R7", mkInstr(2'b01, 1'b0, 5'd1, 3'd0, 5'd2, 4'd3), a, HB, 16'hFFFE,
          16'h4544, 1'b0, 1'b0);
    a = {64'h7FF8000000000000, 64'h3FF0000000000000};
    apply("R7", mkInstr(2'b11, 1'b0, 5'd1, 3'd0, 5'd2, 4'd3), a,
          {64'h3FF8000000000000, 64'hBFF0000000000000}, 16'hFFFF,
          16'h0001, 1'b1, 1'b0);
  endtask

  task automatic testSingle();
    logic [127:0] a, b;
    a = {32'h80000000, 32'h3F800000, 32'hC0400000, 32'h40000000};
    b = {32'h00000000, 32'hC0000000, 32'h40400000, 32'h3F800000};
    apply("R4", mkInstr(2'b10, 1'b1, 5'd0, 3'd1, 5'd0, 4'd0), a, b, 16'hFFFF,
          16'h0001, 1'b0, 1'b0);
    apply("R4", mkInstr(2'b10, 1'b0, 5'd0, 3'd1, 5'd0, 4'd0), a, b, 16'hFFFF,
          16'h1011, 1'b0, 1'b0);
    apply("R6", mkInstr(2'b10, 1'b0, 5'd0, 3'd1, 5'd0, 4'd0), a, b, 16'hFFFE,
          16'h1010, 1'b0, 1'b0);
  endtask

  task automatic testDouble();
    logic [127:0] a, b;
    a = {64'hC000000000000000, 64'h3FF0000000000000};
    b = {64'h3FF8000000000000, 64'hBFF0000000000000};
    apply("R4", mkInstr(2'b11, 1'b0, 5'd0, 3'd0, 5'd0, 4'd0), a, b, 16'hFFFF,
          16'h0101, 1'b0, 1'b0);
    apply("R5", mkInstr(2'b11, 1'b1, 5'd0, 3'd0, 5'd0, 4'd0), a, b, 16'hFFFF,
          16'h0100, 1'b0, 1'b0);
  endtask

  task automatic testUndef();
    logic [31:0] good;
    good = mkInstr(2'b01, 1'b0, 5'd1, 3'd0, 5'd2, 4'd3);
    apply("R3", mkInstr(2'b00, 1'b0, 5'd1, 3'd0, 5'd2, 4'd3), HA, HB, 16'hFFFF,
          16'h0000, 1'b0, 1'b1);
    apply("R1", {8'h64, good[23:0]}, HA, HB, 16'hFFFF, 16'h0000, 1'b0, 1'b1);
    apply("R1", good | 32'h0020_0000, HA, HB, 16'hFFFF, 16'h0000, 1'b0, 1'b1);
    apply("R1", good & ~32'h0000_0010, HA, HB, 16'hFFFF, 16'h0000, 1'b0, 1'b1);
    apply("R1", good & ~32'h0000_4000, HA, HB, 16'hFFFF, 16'h0000, 1'b0, 1'b1);
  endtask

  task automatic testIndicesAndIdle();
    apply("R10", mkInstr(2'b10, 1'b0, 5'd17, 3'd5, 5'd9, 4'd12), HA, HB,
          16'hFFFF, 16'h1111 & 16'h0000 | 16'h0000, 1'b0, 1'b0);
  endtask

  task automatic testIdx();
    logic [15:0] eP;
    logic eInv, eUnd;
    logic [31:0] ins;
    ins = mkInstr(2'b10, 1'b0, 5'd17, 3'd5, 5'd9, 4'd12);
    model(ins, HA, HB, 16'hFFFF, eP, eInv, eUnd);
    @(negedge clk);
    instr = ins; srcA = HA; srcB = HB; govPred = 16'hFFFF; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R10", "srcBIdx", 32'(srcBIdx), 32'd17);
    chk("R10", "predIdx", 32'(predIdx), 32'd5);
    chk("R10", "srcAIdx", 32'(srcAIdx), 32'd9);
    chk("R10", "destIdx", 32'(destIdx), 32'd12);
    chk("R10", "destPred", 32'(destPred), 32'(eP));
    // R9 idle cycle: everything returns to zero
    @(negedge clk);
    chk("R9", "idle outValid", 32'(outValid), 32'd0);
    chk("R9", "idle destPred", 32'(destPred), 32'd0);
    chk("R9", "idle undefInstr", 32'(undefInstr), 32'd0);
    chk("R10", "idle destIdx", 32'(destIdx), 32'd0);
  endtask

  task automatic testRandom();
    logic [127:0] a, b;
    logic [15:0] p;
    for (int i = 0; i < 150; i++) begin
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      if (i % 3 == 0) b = a ^ {8{16'h8000}} ^ {4{32'h8000_0000}};
      if (i % 5 == 1) b = a;
      p = 16'($urandom);
      applyModel("R5", mkInstr(2'(1 + i % 3), 1'(i / 3), 5'd0, 3'd0, 5'd0, 4'd0),
                 a, b, p);
    end
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testHalf();
    testPredicate();
    testNan();
    testSingle();
    testDouble();
    testUndef();
    testIdx();
    testRandom();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule